// File: doc/BRIEF.md
# Half-Space Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and two 512 KB memories, one flash and one static RAM. It turns each CPU memory cycle into a 19-bit physical address, a chip select for one of the two devices, and a read or write enable. The CPU address space is split at its midpoint. The upper half is permanently wired to the first 32 KB of the RAM, so it serves as shared memory. The lower half shows whichever 32 KB window of flash or RAM a one-byte bank register names.

The CPU changes the register with a single I/O write to a port number that is set by a parameter. A write takes effect on the rising edge of the I/O write strobe. Bits 3:0 of the written byte give the window number and bit 4 chooses the device. Reset clears the register, so flash window 0 appears at address zero and the CPU can boot from it. Boot code copies itself into the shared upper half, then switches the lower half to RAM. Later it can bring any flash window into view, to read it as a ROM disk or to program it in system.

Top module: `half_bank_mapper`

## Requirements
- R1: After reset the register holds zero: a read of any address 0x0000–0x7FFF asserts the flash select with physical address bits 18:15 equal to 0.
- R2: Every access to 0x8000–0xFFFF asserts the RAM select, never the flash select, with physical bits 18:15 equal to 0, whatever the register holds.
- R3: For 0x0000–0x7FFF, physical bits 18:15 equal register bits 3:0, and physical bits 14:0 always equal CPU address bits 14:0.
- R4: For 0x0000–0x7FFF, register bit 4 chooses the device: 0 selects flash and 1 selects RAM.
- R5: One I/O write strobe pulse to the bank port loads bits 4:0 of the I/O data into the register. The load happens on the first clock edge that sees the strobe high after it was low.
- R6: Strobes to any other port number leave the register unchanged. Holding the strobe high across later clock edges does not load the register again, even if the data changes. I/O data bits 7:5 have no effect.
- R7: A flash window other than 0 selected in the register is readable in the lower half: a read asserts the flash select and the output enable, with that window on bits 18:15.
- R8: The flash select and the RAM select are never asserted together. Both are off when the memory request is off, when neither read nor write is asserted, or when read and write are asserted together.
- R9: The output enable follows a memory read and the write enable follows a memory write. A write to the lower half while flash is mapped asserts the write enable together with the flash select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the bank register |
| cpu_addr | input | 16 | CPU memory address |
| cpu_mreq | input | 1 | Memory request, active high |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, active high |
| phys_addr | output | 19 | Physical address shared by both memories |
| rom_sel | output | 1 | Flash chip select, active high |
| ram_sel | output | 1 | RAM chip select, active high |
| mem_oe | output | 1 | Output enable for a read |
| mem_we | output | 1 | Write enable for a write |

## Verification
The bench uses the default parameters: a 16-bit CPU space, a 4-bit window number and bank port 0x3C. With only 32 register codes and one address bit steering the split, random stimulus reaches every window on both devices and both halves many times. Directed cases cover port values next to the bank port, a strobe held high while its data changes, and the read-and-write-together state. Set against the bench's own model of the register, they show that one pulse makes exactly one load.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  // Device steered by the decoded address.
  typedef enum logic {
    DEV_ROM = 1'b0,
    DEV_RAM = 1'b1
  } dev_e;

  // Kind of memory cycle the CPU strobes describe.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Classify a memory cycle; contradictory strobes count as idle.
  function automatic acc_e classify(input logic mreq, input logic rd, input logic wr);
    if (!mreq || (rd == wr)) return ACC_IDLE;
    return rd ? ACC_READ : ACC_WRITE;
  endfunction

endpackage

// File: rtl/hbm_bank_reg.sv
module hbm_bank_reg #(
  parameter int unsigned IO_W      = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_W    = 4,
  parameter logic [7:0]  BANK_PORT = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_W-1:0]   io_port,
  input  logic [DATA_W-1:0] io_data,
  input  logic              io_wr,
  output logic [PAGE_W-1:0] bank_win,
  output logic              bank_ram,
  output logic              wr_hit
);

  localparam int unsigned RAM_BIT = PAGE_W;

  logic io_wr_q;
  logic strobe_rise;
  logic port_match;
  logic unused_hi_bits;

  assign unused_hi_bits = ^io_data[DATA_W-1:RAM_BIT+1];

  assign strobe_rise = io_wr & ~io_wr_q;
  assign port_match  = (io_port == BANK_PORT[IO_W-1:0]);
  assign wr_hit      = strobe_rise & port_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_wr_q  <= 1'b0;
      bank_win <= '0;
      bank_ram <= 1'b0;
    end else begin
      io_wr_q <= io_wr;
      if (wr_hit) begin
        bank_win <= io_data[PAGE_W-1:0];
        bank_ram <= io_data[RAM_BIT];
      end
    end
  end

  // R5: one accepted strobe edge loads the window and device bits.
  p_load_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (bank_win == $past(io_data[PAGE_W-1:0])) && (bank_ram == $past(io_data[RAM_BIT])));

  // R6: without an accepted edge the register keeps its value.
  p_hold_otherwise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(bank_win) && $stable(bank_ram));

  // R6: a strobe that was already high cannot load again.
  p_no_reload_while_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && $past(io_wr)) |-> !wr_hit);

endmodule

// File: rtl/hbm_xlate.sv
module hbm_xlate
  import hbm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned COMMON_PAGE = 0
) (
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [PAGE_W-1:0]        bank_win,
  input  logic                     bank_ram,
  output logic [PAGE_W+ADDR_W-2:0] phys_addr,
  output dev_e                     dev
);

  localparam int unsigned OFS_W = ADDR_W - 1;
  localparam logic [PAGE_W-1:0] COMMON_WIN = PAGE_W'(COMMON_PAGE);

  logic upper_half;

  // Window number placed on the physical lines above the offset.
  function automatic logic [PAGE_W-1:0] pick_window(input logic upper,
                                                    input logic [PAGE_W-1:0] win);
    return upper ? COMMON_WIN : win;
  endfunction

  // Device for the access: the upper half is always shared RAM.
  function automatic dev_e pick_device(input logic upper, input logic ram_bit);
    return (upper || ram_bit) ? DEV_RAM : DEV_ROM;
  endfunction

  assign upper_half = cpu_addr[ADDR_W-1];
  assign phys_addr  = {pick_window(upper_half, bank_win), cpu_addr[OFS_W-1:0]};
  assign dev        = pick_device(upper_half, bank_ram);

endmodule

// File: rtl/hbm_strobes.sv
module hbm_strobes
  import hbm_pkg::*;
(
  input  logic cpu_mreq,
  input  logic cpu_rd,
  input  logic cpu_wr,
  input  dev_e dev,
  output logic rom_sel,
  output logic ram_sel,
  output logic mem_oe,
  output logic mem_we,
  output logic cycle_live
);

  acc_e kind;

  assign kind       = classify(cpu_mreq, cpu_rd, cpu_wr);
  assign cycle_live = (kind != ACC_IDLE);
  assign mem_oe     = (kind == ACC_READ);
  assign mem_we     = (kind == ACC_WRITE);
  assign rom_sel    = cycle_live && (dev == DEV_ROM);
  assign ram_sel    = cycle_live && (dev == DEV_RAM);

  // R8: the two chip selects exclude each other.
  always_comb begin
    if (rom_sel && ram_sel) begin
      p_sel_exclusive_r8: assert (1'b0) else $error("both chip selects active");
    end
  end

endmodule

// File: rtl/half_bank_mapper.sv
module half_bank_mapper
  import hbm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned IO_W        = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned COMMON_PAGE = 0,
  parameter logic [7:0]  BANK_PORT   = 8'h3C
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic                     cpu_mreq,
  input  logic                     cpu_rd,
  input  logic                     cpu_wr,
  input  logic [IO_W-1:0]          io_port,
  input  logic [DATA_W-1:0]        io_data,
  input  logic                     io_wr,
  output logic [PAGE_W+ADDR_W-2:0] phys_addr,
  output logic                     rom_sel,
  output logic                     ram_sel,
  output logic                     mem_oe,
  output logic                     mem_we
);

  localparam int unsigned OFS_W  = ADDR_W - 1;
  localparam int unsigned PHYS_W = PAGE_W + OFS_W;

  logic [PAGE_W-1:0] bank_win;
  logic              bank_ram;
  logic              wr_hit;
  logic              cycle_live;
  dev_e              dev;

  hbm_bank_reg #(
    .IO_W(IO_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .BANK_PORT(BANK_PORT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .io_port(io_port), .io_data(io_data), .io_wr(io_wr),
    .bank_win(bank_win), .bank_ram(bank_ram), .wr_hit(wr_hit)
  );

  hbm_xlate #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .COMMON_PAGE(COMMON_PAGE)
  ) u_xlate (
    .cpu_addr(cpu_addr), .bank_win(bank_win), .bank_ram(bank_ram),
    .phys_addr(phys_addr), .dev(dev)
  );

  hbm_strobes u_strobes (
    .cpu_mreq(cpu_mreq), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .dev(dev),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .mem_oe(mem_oe), .mem_we(mem_we),
    .cycle_live(cycle_live)
  );

  // R2: the upper half lands in the shared RAM window.
  p_upper_common_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_live && cpu_addr[ADDR_W-1]) |->
      (ram_sel && !rom_sel && (phys_addr[PHYS_W-1:OFS_W] == PAGE_W'(COMMON_PAGE))));

  // R3: the offset inside a window passes straight through.
  p_offset_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);

  // R8: no select without a live memory cycle.
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_mreq && (cpu_rd ^ cpu_wr)) |-> (!rom_sel && !ram_sel && !mem_oe && !mem_we));

  // R9: a write cycle drives the write enable and never the output enable.
  p_write_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mreq && cpu_wr && !cpu_rd) |-> (mem_we && !mem_oe));

endmodule

// File: tb/half_bank_mapper_test.sv
`timescale 1ns/1ps
module half_bank_mapper_test;

  localparam logic [7:0] PORT = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_mreq = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  io_port = '0, io_data = '0;
  logic        io_wr = 1'b0;
  logic [18:0] phys_addr;
  logic        rom_sel, ram_sel, mem_oe, mem_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the bank register.
  logic [3:0] m_win = '0;
  logic       m_ram = 1'b0;

  always #5 clk = ~clk;

  half_bank_mapper #(.BANK_PORT(PORT)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_mreq(cpu_mreq),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .io_port(io_port), .io_data(io_data),
    .io_wr(io_wr), .phys_addr(phys_addr), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .mem_oe(mem_oe), .mem_we(mem_we)
  );

  function automatic logic [18:0] want_phys(input logic [15:0] a);
    return a[15] ? {4'd0, a[14:0]} : {m_win, a[14:0]};
  endfunction

  function automatic logic [3:0] want_strobes(input logic [15:0] a, input logic mq,
                                              input logic r, input logic w);
    logic rd_ok, wr_ok, on_ram;
    rd_ok  = mq && r && !w;
    wr_ok  = mq && w && !r;
    on_ram = a[15] || m_ram;
    // order: rom_sel, ram_sel, oe, we
    return {(rd_ok || wr_ok) && !on_ram, (rd_ok || wr_ok) && on_ram, rd_ok, wr_ok};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic mq, input logic r,
                        input logic w, input string req);
    logic [3:0] got, exp;
    @(negedge clk);
    cpu_addr = a; cpu_mreq = mq; cpu_rd = r; cpu_wr = w;
    #2;
    exp = want_strobes(a, mq, r, w);
    got = {rom_sel, ram_sel, mem_oe, mem_we};
    check(got == exp, req, 32'(got), 32'(exp));
    check(phys_addr == want_phys(a), req, 32'(phys_addr), 32'(want_phys(a)));
    check(!(rom_sel && ram_sel), "R8", 32'(got), 32'(exp));
  endtask

  // One strobe pulse spanning exactly one rising clock edge.
  task automatic io_write(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    io_port = p; io_data = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (p == PORT) begin
      m_win = d[3:0];
      m_ram = d[4];
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state shows flash window 0 at address zero.
    access(16'h0000, 1, 1, 0, "R1");
    access(16'h7FFF, 1, 1, 0, "R1");
    access(16'h8000, 1, 1, 0, "R2");

    // R7: flash window 5 as ROM disk; R9: write to flash passes the enable.
    io_write(PORT, 8'h05);
    access(16'h1234, 1, 1, 0, "R7");
    access(16'h2345, 1, 0, 1, "R9");
    access(16'hC000, 1, 0, 1, "R2");

    // R4: RAM window 1 in the lower half; bits 7:5 set are ignored (R6).
    io_write(PORT, 8'hF1);
    access(16'h0100, 1, 1, 0, "R4");
    access(16'h4000, 1, 0, 1, "R6");

    // R6: neighbouring ports leave the register alone.
    io_write(PORT + 8'd1, 8'h0A);
    access(16'h0042, 1, 1, 0, "R6");
    io_write(PORT - 8'd1, 8'h1F);
    access(16'h0042, 1, 1, 0, "R6");

    // R5 and R6: strobe held high while data changes loads only once.
    @(negedge clk);
    io_port = PORT; io_data = 8'h0C; io_wr = 1'b1;
    @(negedge clk);
    io_data = 8'h17;
    @(negedge clk);
    @(negedge clk);
    io_wr = 1'b0;
    m_win = 4'hC; m_ram = 1'b0;
    access(16'h3000, 1, 1, 0, "R5");

    // R8: idle and contradictory strobes.
    access(16'h3000, 0, 1, 0, "R8");
    access(16'h9000, 1, 0, 0, "R8");
    access(16'h3000, 1, 1, 1, "R8");

    // R3 and R4: random register values and accesses.
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [7:0] p;
        p = ($urandom_range(0, 4) == 0) ? 8'($urandom) : PORT;
        io_write(p, 8'($urandom));
      end
      access(16'($urandom), 1'($urandom_range(0, 7) != 0),
             1'($urandom), 1'($urandom), "R3");
    end

    // R5: a final directed load after the random run.
    io_write(PORT, 8'h1E);
    access(16'h7001, 1, 1, 0, "R5");

    // R1: reset again clears the register.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_win = '0; m_ram = 1'b0;
    access(16'h0ABC, 1, 1, 0, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule